// File: doc/BRIEF.md
# Bit-Stuffing NRZI Line Transmitter

This block turns a byte-parallel packet stream into the serial line state of a full-speed USB-style link. A source offers bytes with a valid flag and marks the final byte of a packet with a last flag. The transmitter takes one byte per handshake and sends it least significant bit first. It puts a synchronisation pattern in front of the packet. After every run of six consecutive 1 bits it inserts a 0. Every bit is NRZI-encoded onto a single logical line level (J or K). The packet is closed with a single-ended-zero end-of-packet indication on a separate output.

The transmitter advances by one bit time on each clock cycle in which the bit-time enable is high. It does nothing in other cycles, so one clock can serve any bit rate below the clock rate. The run-length count covers the sync pattern, the data and the point just before end of packet. A stuffed bit therefore follows the closing 1 of the sync pattern when needed, and it also follows a run that ends on the final data bit. While a stuffed bit goes out, the byte handshake waits one bit time, so the source never loses a byte.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: After reset, and while no packet is in progress, `line_j` is 1 (J), `line_se0` is 0 and `in_ready` is 0. A reset during a packet returns the line to J.
- R2: `line_j` and `line_se0` change only at a clock edge where `bit_en` was high, and `in_ready` is high only in cycles where `bit_en` is high.
- R3: A bit time in which the block is idle and `in_valid` is high starts a packet. During that bit time the line stays J. The next eight bit times carry the sync bits 0,0,0,0,0,0,0,1, so the line reads K,J,K,J,K,J,K,K.
- R4: Each sent bit is NRZI-encoded. A 0 toggles the line between J (`line_j`=1) and K (`line_j`=0), and a 1 leaves the line unchanged.
- R5: Bytes are sent least significant bit first. A byte is accepted (`in_valid` and `in_ready` both high) in the bit time that sends the final bit of the sync pattern or of the previous byte. A byte accepted with `in_last` high is the final byte of the packet.
- R6: After six consecutive 1 bits a 0 is inserted before the next bit. The closing 1 of the sync pattern counts as the first 1 of a run.
- R7: When a stuffed bit falls in the bit time that would send a byte's final bit, that bit and the handshake move one bit time later. Every data bit is sent exactly once.
- R8: If the final data bit completes a run of six 1s, a stuffed 0 is still sent before end of packet.
- R9: End of packet is two bit times with `line_se0`=1 and `line_j`=0, then one bit time of J, after which the block is idle.
- R10: If `in_valid` is low when the next byte is due, the packet closes as if the previous byte had been the last one (stuffing if due, then end of packet).
- R11: While a packet is in progress, the line never holds one level for more than seven consecutive bit times outside end of packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One bit time elapses in each cycle where this is high |
| in_data | input | 8 | Packet byte offered by the source |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The offered byte is the final byte of the packet |
| in_ready | output | 1 | The offered byte is taken at this clock edge |
| line_j | output | 1 | Line level: 1 = J, 0 = K (0 during SE0) |
| line_se0 | output | 1 | Single-ended zero (end of packet) |

## Verification
The bench builds the block with 8-bit bytes, a run limit of six and a two-bit-time SE0. With these values, packets of one to four bytes place runs of 1s across byte boundaries, after the closing sync 1, just before a byte's final bit and at the very end of the packet. It drives the bit-time enable every clock, every second clock and every third clock. This covers back-to-back bit times and gapped bit times, and it shows whether the line holds still between enables.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_EOP  = 2'd2,
    ST_JEND = 2'd3
  } tx_state_e;

  // What the line does in the current bit time
  typedef enum logic [1:0] {
    EM_HOLD = 2'd0,
    EM_BIT  = 2'd1,
    EM_SE0  = 2'd2,
    EM_J    = 2'd3
  } emit_e;

  // Line level after sending bit b from level cur
  function automatic logic nrzi_level(input logic cur, input logic b);
    return b ? cur : ~cur;
  endfunction

  // Consecutive-ones count after sending bit b
  function automatic int unsigned run_next(input int unsigned cnt, input logic b);
    return b ? cnt + 1 : 0;
  endfunction

endpackage

// File: rtl/nrzi_tx_runlen.sv
module nrzi_tx_runlen
  import nrzi_tx_pkg::*;
#(
  parameter int RUN_MAX = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_en,
  input  emit_e emit_kind,
  input  logic  emit_bit,
  output logic  stuff_due
);
  localparam int RW = $clog2(RUN_MAX + 1);

  logic [RW-1:0] ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (bit_en) begin
      if (emit_kind == EM_BIT) begin
        ones_q <= RW'(run_next(int'(ones_q), emit_bit));
      end else begin
        ones_q <= '0;
      end
    end
  end

  assign stuff_due = (ones_q == RW'(RUN_MAX));

endmodule

// File: rtl/nrzi_tx_line.sv
module nrzi_tx_line
  import nrzi_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_en,
  input  emit_e emit_kind,
  input  logic  emit_bit,
  output logic  line_j,
  output logic  line_se0
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_j   <= 1'b1;
      line_se0 <= 1'b0;
    end else if (bit_en) begin
      unique case (emit_kind)
        EM_BIT: begin
          line_j   <= nrzi_level(line_j, emit_bit);
          line_se0 <= 1'b0;
        end
        EM_SE0: begin
          line_j   <= 1'b0;
          line_se0 <= 1'b1;
        end
        EM_J: begin
          line_j   <= 1'b1;
          line_se0 <= 1'b0;
        end
        default: begin
          line_j   <= line_j;
          line_se0 <= line_se0;
        end
      endcase
    end
  end

endmodule

// File: rtl/nrzi_tx_ctrl.sv
module nrzi_tx_ctrl
  import nrzi_tx_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int EOP_SE0_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              stuff_due,
  output logic              in_ready,
  output emit_e             emit_kind,
  output logic              emit_bit,
  output logic              stuff_ev,
  output logic              tx_busy
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int EW    = $clog2(EOP_SE0_BITS + 1);
  localparam logic [BYTE_W-1:0] SYNC_PAT = {1'b1, {(BYTE_W-1){1'b0}}};

  tx_state_e         state_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic              final_q;
  logic [EW-1:0]     eop_cnt_q;

  logic byte_end;
  logic send_bit;
  logic byte_take;

  assign byte_end  = (bcnt_q == CNT_W'(BYTE_W - 1));
  assign send_bit  = bit_en && (state_q == ST_SEND) && !stuff_due;
  assign in_ready  = send_bit && byte_end && !final_q;
  assign byte_take = in_ready && in_valid;
  assign stuff_ev  = bit_en && stuff_due && ((state_q == ST_SEND) || (state_q == ST_EOP));
  assign tx_busy   = (state_q == ST_SEND) || (state_q == ST_EOP);

  always_comb begin
    emit_kind = EM_HOLD;
    emit_bit  = 1'b0;
    unique case (state_q)
      ST_SEND: begin
        emit_kind = EM_BIT;
        emit_bit  = stuff_due ? 1'b0 : shreg_q[0];
      end
      ST_EOP: begin
        emit_kind = stuff_due ? EM_BIT : EM_SE0;
      end
      ST_JEND: emit_kind = EM_J;
      default: emit_kind = EM_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      bcnt_q    <= '0;
      final_q   <= 1'b0;
      eop_cnt_q <= '0;
    end else if (bit_en) begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            state_q <= ST_SEND;
            shreg_q <= SYNC_PAT;
            bcnt_q  <= '0;
            final_q <= 1'b0;
          end
        end
        ST_SEND: begin
          if (!stuff_due) begin
            if (byte_end) begin
              if (byte_take) begin
                shreg_q <= in_data;
                bcnt_q  <= '0;
                final_q <= in_last;
              end else begin
                state_q   <= ST_EOP;
                eop_cnt_q <= '0;
              end
            end else begin
              shreg_q <= shreg_q >> 1;
              bcnt_q  <= bcnt_q + CNT_W'(1);
            end
          end
        end
        ST_EOP: begin
          if (!stuff_due) begin
            if (eop_cnt_q == EW'(EOP_SE0_BITS - 1)) begin
              state_q   <= ST_JEND;
              eop_cnt_q <= '0;
            end else begin
              eop_cnt_q <= eop_cnt_q + EW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
  import nrzi_tx_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int RUN_MAX      = 6,
  parameter int EOP_SE0_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              line_j,
  output logic              line_se0
);

  emit_e emit_kind;
  logic  emit_bit;
  logic  stuff_due;
  logic  stuff_ev;
  logic  tx_busy;

  nrzi_tx_ctrl #(
    .BYTE_W      (BYTE_W),
    .EOP_SE0_BITS(EOP_SE0_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .stuff_due(stuff_due),
    .in_ready (in_ready),
    .emit_kind(emit_kind),
    .emit_bit (emit_bit),
    .stuff_ev (stuff_ev),
    .tx_busy  (tx_busy)
  );

  nrzi_tx_runlen #(
    .RUN_MAX(RUN_MAX)
  ) u_runlen (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .emit_kind(emit_kind),
    .emit_bit (emit_bit),
    .stuff_due(stuff_due)
  );

  nrzi_tx_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .emit_kind(emit_kind),
    .emit_bit (emit_bit),
    .line_j   (line_j),
    .line_se0 (line_se0)
  );

endmodule

// File: rtl/nrzi_stuff_tx_chk.sv
module nrzi_stuff_tx_chk #(
  parameter int RUN_MAX = 6
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_ready,
  input logic line_j,
  input logic line_se0,
  input logic stuff_ev,
  input logic tx_busy
);
  localparam int SW = $clog2(RUN_MAX + 2) + 1;

  logic          tick_d;
  logic          lvl_prev;
  logic [SW-1:0] same_cnt;

  // Counts bit times the line has kept one level during a packet
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_d   <= 1'b0;
      lvl_prev <= 1'b1;
      same_cnt <= '0;
    end else begin
      tick_d <= bit_en;
      if (bit_en) lvl_prev <= line_j;
      if (tick_d) begin
        if (line_se0 || !tx_busy || (line_j != lvl_prev)) same_cnt <= '0;
        else same_cnt <= same_cnt + SW'(1);
      end
    end
  end

  p_idle_is_j_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !line_se0) |-> line_j);

  p_line_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> ($stable(line_j) && $stable(line_se0)));

  p_ready_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);

  p_stuff_toggles_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_ev |=> ((line_j != $past(line_j)) && !line_se0));

  p_eop_then_j_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_se0) |-> line_j);

  p_transition_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    same_cnt <= SW'(RUN_MAX));

endmodule

bind nrzi_stuff_tx nrzi_stuff_tx_chk #(.RUN_MAX(RUN_MAX)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_en  (bit_en),
  .in_ready(in_ready),
  .line_j  (line_j),
  .line_se0(line_se0),
  .stuff_ev(stuff_ev),
  .tx_busy (tx_busy)
);

// File: tb/nrzi_stuff_tx_bench.sv
module nrzi_stuff_tx_bench;
  localparam int BYTE_W = 8;
  localparam int RUN_MAX = 6;
  localparam int EOP_SE0_BITS = 2;
  localparam int NVEC = 13;
  localparam int SEQ_MAX = 96;

  // {len[38:36], b0, b1, b2, b3, expected stuffed bits[3:0]}
  localparam logic [38:0] VEC [NVEC] = '{
    {3'd1, 8'h00, 8'h00, 8'h00, 8'h00, 4'd0},
    {3'd1, 8'h1F, 8'h00, 8'h00, 8'h00, 4'd1},
    {3'd1, 8'h3E, 8'h00, 8'h00, 8'h00, 4'd0},
    {3'd1, 8'h7E, 8'h00, 8'h00, 8'h00, 4'd1},
    {3'd1, 8'hFE, 8'h00, 8'h00, 8'h00, 4'd1},
    {3'd1, 8'hFC, 8'h00, 8'h00, 8'h00, 4'd1},
    {3'd2, 8'hFF, 8'hFF, 8'h00, 8'h00, 4'd2},
    {3'd2, 8'h80, 8'h3F, 8'h00, 8'h00, 4'd1},
    {3'd3, 8'hC0, 8'hFF, 8'h03, 8'h00, 4'd2},
    {3'd4, 8'hA5, 8'h5A, 8'h00, 8'hFF, 4'd1},
    {3'd2, 8'h00, 8'hFC, 8'h00, 8'h00, 4'd1},
    {3'd1, 8'hFF, 8'h00, 8'h00, 8'h00, 4'd1},
    {3'd2, 8'h7E, 8'h01, 8'h00, 8'h00, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic [BYTE_W-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic in_ready;
  logic line_j;
  logic line_se0;

  always #2 clk = ~clk;

  nrzi_stuff_tx #(
    .BYTE_W(BYTE_W), .RUN_MAX(RUN_MAX), .EOP_SE0_BITS(EOP_SE0_BITS)
  ) u_nrzi_stuff_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .line_j(line_j), .line_se0(line_se0)
  );

  int checks = 0;
  int fails = 0;

  logic [1:0] exp_seq [SEQ_MAX];
  logic [1:0] act_seq [SEQ_MAX];
  int exp_n;
  int act_n;
  int takes;
  bit hold_bad;
  bit rdy_bad;
  logic m_lvl;
  int m_ones;
  int m_stuff;

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic push_exp(input logic [1:0] v);
    if (exp_n < SEQ_MAX) exp_seq[exp_n] = v;
    exp_n++;
  endtask

  // Reference: NRZI with zero insertion after RUN_MAX ones
  task automatic model_bit(input logic b);
    m_lvl = b ? m_lvl : ~m_lvl;
    push_exp({1'b0, m_lvl});
    m_ones = b ? m_ones + 1 : 0;
    if (m_ones == RUN_MAX) begin
      m_lvl = ~m_lvl;
      push_exp({1'b0, m_lvl});
      m_ones = 0;
      m_stuff++;
    end
  endtask

  task automatic build_model(input logic [31:0] bytes, input int len);
    exp_n = 0; m_lvl = 1'b1; m_ones = 0; m_stuff = 0;
    push_exp(2'b01);
    for (int k = 0; k < 8; k++) model_bit(k == 7);
    for (int b = 0; b < len; b++)
      for (int i = 0; i < BYTE_W; i++) model_bit(bytes[8*b+i]);
    for (int e = 0; e < EOP_SE0_BITS; e++) push_exp(2'b10);
    push_exp(2'b01);
  endtask

  task automatic drive_packet(input logic [31:0] bytes, input int len, input bit use_last,
                              input int div);
    logic [1:0] obs;
    logic [1:0] last_obs;
    bit prev_tick = 1'b0;
    bit hs = 1'b0;
    bit seen_se0 = 1'b0;
    bit done = 1'b0;
    int bi = 0;
    int cyc = 0;
    act_n = 0; takes = 0; hold_bad = 1'b0; rdy_bad = 1'b0;
    last_obs = {line_se0, line_j};
    in_valid = 1'b1;
    in_data = bytes[7:0];
    in_last = use_last && (len == 1);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      obs = {line_se0, line_j};
      if (!prev_tick && obs != last_obs) hold_bad = 1'b1;
      if (prev_tick && act_n < SEQ_MAX) begin
        act_seq[act_n] = obs;
        act_n++;
        if (obs[1]) seen_se0 = 1'b1;
        else if (seen_se0) done = 1'b1;
      end
      last_obs = obs;
      if (hs) begin
        takes++;
        bi++;
        if (bi < len) begin
          in_data = bytes[8*bi +: 8];
          in_last = use_last && (bi == len - 1);
        end else begin
          in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        end
      end
      bit_en = done ? 1'b0 : ((cyc % div) == 0);
      cyc++;
      prev_tick = bit_en;
      #1;
      hs = in_valid && in_ready;
      if (in_ready && !bit_en) rdy_bad = 1'b1;
    end
    bit_en = 1'b0; in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_packet(input logic [31:0] bytes, input int len, input bit use_last,
                            input int div, input int exp_stuff, input string name);
    int bad;
    int first;
    int run;
    int maxrun;
    build_model(bytes, len);
    drive_packet(bytes, len, use_last, div);
    // R3: start bit time and sync pattern
    bad = 0;
    for (int i = 0; i < 9; i++) if (i >= act_n || act_seq[i] != exp_seq[i]) bad++;
    check(bad == 0, {"R3 sync prefix ", name}, bad, 0);
    // R4, R5, R7: whole line sequence against the reference model
    bad = 0; first = -1;
    for (int i = 0; i < exp_n && i < SEQ_MAX; i++)
      if (i >= act_n || act_seq[i] != exp_seq[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    check(bad == 0 && act_n == exp_n, {"R4 R5 R7 line sequence ", name},
          (first < 0) ? act_n : int'(act_seq[first]), (first < 0) ? exp_n : int'(exp_seq[first]));
    // R6, R8: packet length reveals the stuffed-bit count from the table
    check(act_n == 1 + 8 + 8*len + exp_stuff + EOP_SE0_BITS + 1,
          {"R6 R8 stuffed length ", name}, act_n,
          1 + 8 + 8*len + exp_stuff + EOP_SE0_BITS + 1);
    // R9: end of packet tail
    bad = 0;
    if (act_n < 3) bad = 1;
    else if (act_seq[act_n-3] != 2'b10 || act_seq[act_n-2] != 2'b10 ||
             act_seq[act_n-1] != 2'b01) bad = 1;
    check(bad == 0, {"R9 eop tail ", name}, bad, 0);
    // R2: outputs hold between enables; ready only with enable
    check(!hold_bad && !rdy_bad, {"R2 enable gating ", name}, int'(hold_bad) + 2*int'(rdy_bad), 0);
    // R5: handshake count
    check(takes == len, {"R5 bytes accepted ", name}, takes, len);
    // R11: longest constant-level stretch
    run = 0; maxrun = 0;
    for (int i = 1; i < act_n; i++) begin
      if (act_seq[i][1]) run = 0;
      else if (act_seq[i] == act_seq[i-1]) run++;
      else run = 0;
      if (run + 1 > maxrun) maxrun = run + 1;
    end
    check(maxrun <= RUN_MAX + 1, {"R11 transition density ", name}, maxrun, RUN_MAX + 1);
  endtask

  initial begin
    #600000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(line_j == 1'b1 && line_se0 == 1'b0 && in_ready == 1'b0,
          "R1 reset state", {line_j, line_se0, in_ready}, 3'b100);
    rst_n = 1'b1;
    // R1: idle bit times without valid
    bit_en = 1'b1;
    repeat (5) begin
      @(negedge clk);
      #1;
      check(line_j == 1'b1 && line_se0 == 1'b0 && in_ready == 1'b0,
            "R1 idle with enable", {line_j, line_se0, in_ready}, 3'b100);
    end
    bit_en = 1'b0;
    @(negedge clk);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      run_packet({VEC[v][11:4], VEC[v][19:12], VEC[v][27:20], VEC[v][35:28]},
                 int'(VEC[v][38:36]), 1'b1, (v % 2 == 1) ? 2 : 3,
                 int'(VEC[v][3:0]), $sformatf("vec%0d", v));
      repeat (2) @(negedge clk);
    end

    // Enable every clock, two packets back to back
    run_packet(32'h0000FFFF, 2, 1'b1, 1, 2, "continuous_ff");
    run_packet(32'h000000FC, 1, 1'b1, 1, 1, "continuous_trail");

    // R10: source drops valid instead of flagging last
    run_packet(32'h000000FC, 1, 1'b0, 3, 1, "underrun_single");
    check(act_n == 1 + 8 + 8 + 1 + EOP_SE0_BITS + 1, "R10 underrun closes packet",
          act_n, 1 + 8 + 8 + 1 + EOP_SE0_BITS + 1);
    run_packet(32'h00007E3F, 2, 1'b0, 2, 2, "underrun_pair");
    check(takes == 2, "R10 underrun handshake count", takes, 2);

    // R1: reset during a packet
    in_valid = 1'b1; in_data = 8'h00; in_last = 1'b1; bit_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; bit_en = 1'b0;
    @(negedge clk);
    check(line_j == 1'b1 && line_se0 == 1'b0 && in_ready == 1'b0,
          "R1 reset mid packet", {line_j, line_se0, in_ready}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    run_packet(32'h0000001F, 1, 1'b1, 2, 1, "after_reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule